// File: doc/BRIEF.md
# Oscillator Start-up Stabilization Timer

This block tells the rest of the chip when a freshly restarted oscillator can be trusted. Power management drives a stop request. While the request is high, the block turns the oscillator enable off and loads an internal down-counter with its all-ones value. When the request drops, the enable comes back on. The release is carried into the oscillator clock domain through a short synchronizer chain. After that the counter runs down on the restarting clock itself. When it reaches zero it freezes there and raises a clock-good flag.

Two parameters select the variant: the counter width and a prescale factor. A prescale of N means the counter steps once every N oscillator cycles. The main-clock instance (14 bits, prescale 2) therefore waits 2 + 2·(2^14 − 1) = 32,768 rising edges after the release. The slow-clock instance (6 bits, prescale 1) runs on the 32.768 kHz oscillator and waits 2 + 63 = 65 edges. In general the good flag rises right after rising edge number 2 + P·(2^W − 1), counted from the release.

Top module: `osc_settle_timer`

## Requirements
- R1: While stop_osc is high, osc_enable and clock_good are both low, whatever the clock does.
- R2: osc_enable equals the inverse of stop_osc and changes in the same instant, with no clock edge involved.
- R3: After a release, clock_good is low through rising edge 1 + P·(2^W − 1) and goes high right after edge 2 + P·(2^W − 1). Edges are counted from the release; W is COUNT_W and P is PRESCALE. This holds because the counter starts from its all-ones preset.
- R4: The first two rising edges after a release are spent in the synchronizer, so no counting happens on them. For W=2, P=1 the flag rises after edge 5 and not after edge 3.
- R5: With default parameters (COUNT_W=14, PRESCALE=2), clock_good is low after edge 32,767 and high after edge 32,768.
- R6: With COUNT_W=6 and PRESCALE=1, clock_good is low after edge 64 and high after edge 65.
- R7: Once clock_good is high, it stays high for as long as stop_osc stays low. The count holds at zero.
- R8: A rise of stop_osc pulls clock_good low immediately, before the next clock edge.
- R9: If stop_osc is raised again while the count is in progress, the full preset is reloaded. The next release takes the whole R3 delay again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Clock from the oscillator being supervised |
| stop_osc | input | 1 | Stop request from power management; asynchronous preset, active high |
| osc_enable | output | 1 | Oscillator run enable, high when not stopped |
| clock_good | output | 1 | High once the start-up delay has elapsed since the last release |

## Verification
A counter that starts from the wrong value, skips a step or fails to freeze has only one place to show up: the single-cycle edge of clock_good. A counter that leaks past zero would wrap and drop the flag again. The bench therefore compares clock_good on every cycle against an edge count kept since the last release. Any error in the delay length shows up on the first wrong edge, and an error in the freeze shows up one cycle after zero. A synchronizer with the wrong depth moves that edge by whole cycles, and a stop that is not asynchronous leaves the flag high for part of a cycle. Both are checked directly after they happen.

// File: rtl/osc_stab_pkg.sv
// Shared constants for the oscillator start-up stabilization timer.
// Assumes: nothing beyond IEEE 1800-2017.
package osc_stab_pkg;
    // Depth of the release synchronizer in the oscillator domain.
    localparam int SYNC_STAGES = 2;

    // Number of rising edges after release until the good flag rises.
    function automatic int settle_edges(input int width, input int prescale);
        return SYNC_STAGES + prescale * ((1 << width) - 1);
    endfunction
endpackage

// File: rtl/osc_release_sync.sv
// Release synchronizer: stop_osc presets every stage asynchronously.
// Its fall is shifted in through STAGES flops on osc_clk.
// Assumes: STAGES >= 2; stop_osc may change at any time.
module osc_release_sync #(
    parameter int STAGES = 2
) (
    input  logic osc_clk,
    input  logic stop_osc,
    output logic hold
);
    logic [STAGES-1:0] chain;

    // Shift zeros in after release; preset to all ones on stop.
    always_ff @(posedge osc_clk or posedge stop_osc) begin
        if (stop_osc) chain <= '1;
        else          chain <= {chain[STAGES-2:0], 1'b0};
    end

    assign hold = chain[STAGES-1];

    // R4: the last stage never clears before the first stage has cleared.
    p_chain_order_r4: assert property (@(posedge osc_clk) disable iff (stop_osc)
        !hold |-> !chain[0]);
endmodule

// File: rtl/osc_step_prescaler.sv
// Step prescaler: emits a one-cycle step every PRESCALE cycles while run is high.
// With PRESCALE == 1 it is just a wire.
// Assumes: run stays low until the synchronizer has released.
module osc_step_prescaler #(
    parameter int PRESCALE = 2
) (
    input  logic osc_clk,
    input  logic stop_osc,
    input  logic run,
    output logic step
);
    generate
        if (PRESCALE == 1) begin : g_direct
            assign step = run;
        end else begin : g_divided
            localparam int PW = $clog2(PRESCALE);
            localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
            logic [PW-1:0] phase;

            // Phase counter that wraps at PRESCALE; cleared by stop.
            always_ff @(posedge osc_clk or posedge stop_osc) begin
                if (stop_osc)            phase <= '0;
                else if (run)            phase <= (phase == LAST) ? '0 : phase + 1'b1;
            end

            assign step = run && (phase == LAST);

            // R3: the phase never leaves its range.
            p_phase_range_r3: assert property (@(posedge osc_clk) disable iff (stop_osc)
                phase <= LAST);
        end
    endgenerate
endmodule

// File: rtl/osc_settle_counter.sv
// Settle counter: asynchronously preset to all ones by stop.
// It decrements on each step and freezes at zero.
// Assumes: step is already gated by the synchronizer release.
module osc_settle_counter #(
    parameter int COUNT_W = 14
) (
    input  logic osc_clk,
    input  logic stop_osc,
    input  logic step,
    output logic at_zero
);
    logic [COUNT_W-1:0] count;

    // Count down toward zero and stick there; reload preset on stop.
    always_ff @(posedge osc_clk or posedge stop_osc) begin
        if (stop_osc)                      count <= '1;
        else if (step && (count != '0))    count <= count - 1'b1;
    end

    assign at_zero = (count == '0);

    // R7: zero is terminal while stop stays low.
    p_sticky_zero_r7: assert property (@(posedge osc_clk) disable iff (stop_osc)
        at_zero |=> at_zero);
    // R3: the count never rises between stops.
    p_no_increase_r3: assert property (@(posedge osc_clk) disable iff (stop_osc)
        1'b1 |=> count <= $past(count));
endmodule

// File: rtl/osc_settle_timer.sv
// Oscillator start-up stabilization timer (top).
// stop_osc gates the oscillator and presets the state. After release the
// good flag rises 2 + PRESCALE*(2^COUNT_W - 1) rising edges later.
// Assumes: osc_clk runs whenever osc_enable is high; stop_osc is asynchronous.
module osc_settle_timer
    import osc_stab_pkg::*;
#(
    parameter int COUNT_W  = 14,
    parameter int PRESCALE = 2
) (
    input  logic osc_clk,
    input  logic stop_osc,
    output logic osc_enable,
    output logic clock_good
);
    logic hold;
    logic step;
    logic at_zero;

    osc_release_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .osc_clk  (osc_clk),
        .stop_osc (stop_osc),
        .hold     (hold)
    );

    osc_step_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .osc_clk  (osc_clk),
        .stop_osc (stop_osc),
        .run      (!hold),
        .step     (step)
    );

    osc_settle_counter #(.COUNT_W(COUNT_W)) u_cnt (
        .osc_clk  (osc_clk),
        .stop_osc (stop_osc),
        .step     (step),
        .at_zero  (at_zero)
    );

    // Oscillator runs whenever no stop is requested.
    assign osc_enable = !stop_osc;
    // Good once the counter has drained; the preset clears it asynchronously.
    assign clock_good = at_zero;

    // R1: nothing is reported good while stopped.
    p_quiet_stopped_r1: assert property (@(negedge osc_clk)
        stop_osc |-> (!clock_good && !osc_enable));
    // R4: good is never reported while the release is still in the synchronizer.
    p_good_after_sync_r4: assert property (@(posedge osc_clk) disable iff (stop_osc)
        clock_good |-> !hold);
endmodule

// File: tb/tb_osc_settle_timer.sv
module tb_osc_settle_timer;
    logic clk = 1'b0;
    logic stop_osc;
    logic en_m, good_m, en_s, good_s, en_t, good_t;
    int   checks = 0;
    int   errors = 0;
    int   edges  = 0;
    bit   done   = 1'b0;

    localparam int N_MAIN = 32768;
    localparam int N_SLOW = 65;
    localparam int N_TINY = 5;

    always #10 clk = ~clk;

    osc_settle_timer dut (
        .osc_clk(clk), .stop_osc(stop_osc), .osc_enable(en_m), .clock_good(good_m));
    osc_settle_timer #(.COUNT_W(6), .PRESCALE(1)) dut_slow (
        .osc_clk(clk), .stop_osc(stop_osc), .osc_enable(en_s), .clock_good(good_s));
    osc_settle_timer #(.COUNT_W(2), .PRESCALE(1)) dut_tiny (
        .osc_clk(clk), .stop_osc(stop_osc), .osc_enable(en_t), .clock_good(good_t));

    // Reference: rising edges seen since the last release.
    always @(posedge clk or posedge stop_osc) begin
        if (stop_osc) edges <= 0;
        else          edges <= edges + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", tag, act, exp, edges);
        end
    endtask

    // Continuous comparison against the reference on every falling edge.
    always @(negedge clk) begin
        if (!done && stop_osc !== 1'bx) begin
            check(en_m == !stop_osc, "R2 main enable", en_m, !stop_osc);
            check(en_s == !stop_osc, "R2 slow enable", en_s, !stop_osc);
            check(good_m == (!stop_osc && edges >= N_MAIN), "R3 main good", good_m,
                  (!stop_osc && edges >= N_MAIN));
            check(good_s == (!stop_osc && edges >= N_SLOW), "R3 slow good", good_s,
                  (!stop_osc && edges >= N_SLOW));
            check(good_t == (!stop_osc && edges >= N_TINY), "R3 tiny good", good_t,
                  (!stop_osc && edges >= N_TINY));
        end
    end

    task automatic wait_edges(input int k);
        do @(negedge clk); while (edges != k);
    endtask

    task automatic release_stop();
        @(negedge clk);
        #1 stop_osc = 1'b0;
        #1 check(en_m == 1'b1, "R2 enable on release", en_m, 1);
    endtask

    task automatic async_stop();
        @(posedge clk);
        #4 stop_osc = 1'b1;
        #1;
        check(good_m == 1'b0, "R8 main good drop", good_m, 0);
        check(good_s == 1'b0, "R8 slow good drop", good_s, 0);
        check(en_m == 1'b0, "R1 enable off", en_m, 0);
    endtask

    initial begin
        stop_osc = 1'b1;
        repeat (5) @(negedge clk);
        check(!good_m && !en_m && !good_s, "R1 stopped state", good_m, 0);

        release_stop();
        wait_edges(N_TINY - 1);
        check(good_t == 1'b0, "R4 tiny before", good_t, 0);
        wait_edges(N_TINY);
        check(good_t == 1'b1, "R4 tiny at", good_t, 1);
        wait_edges(N_SLOW - 1);
        check(good_s == 1'b0, "R6 slow before", good_s, 0);
        wait_edges(N_SLOW);
        check(good_s == 1'b1, "R6 slow at", good_s, 1);
        wait_edges(N_MAIN - 1);
        check(good_m == 1'b0, "R5 main before", good_m, 0);
        wait_edges(N_MAIN);
        check(good_m == 1'b1, "R5 main at", good_m, 1);
        wait_edges(N_MAIN + 200);
        check(good_m && good_s && good_t, "R7 sticky good", good_m, 1);

        async_stop();
        repeat (4) @(negedge clk);
        check(!good_m && !good_t, "R1 held stopped", good_m, 0);

        // Restart, abort mid-count, then a full restart.
        release_stop();
        wait_edges(10000);
        async_stop();
        repeat (3) @(negedge clk);
        release_stop();
        wait_edges(N_MAIN - 1);
        check(good_m == 1'b0, "R9 reload before", good_m, 0);
        wait_edges(N_MAIN);
        check(good_m == 1'b1, "R9 reload at", good_m, 1);
        repeat (20) @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", edges, N_MAIN);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule